// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protect Unit

This unit holds the status state of a serial EEPROM and rules on every write the command front-end wants to start. It keeps four pieces of state. The write-enable latch is volatile. The protect-pin enable and the two region-select bits persist across a warm reset. The ready/busy flag mirrors the write timer. The front-end sends decoded one-cycle strobes: enable, disable, array write with its start address, and status write with its data byte. For each write request the unit returns exactly one registered pulse, either a grant or a cancel.

The status byte is always available for the status-read path. It is built as follows:

| Bit | Meaning |
|-----|---------|
| 7 | protect-pin enable |
| 6..4 | zero |
| 3..2 | region select, bit 3 is the upper bit |
| 1 | write-enable latch |
| 0 | busy |

A second address port answers, with no clock, whether one byte of a page burst may be committed. The front-end uses it to suppress single bytes.

No data stream passes through this block. Every pin is a plain control or status signal, so there is no back-pressure. The strobes are one clock wide, and at most one request is raised in a cycle. If an array write and a status write do arrive together, the array write is judged and the status write is cancelled.

Top module: `eewp_status_unit`

## Requirements
- R1: `status_byte` = {pin-enable, 3'b000, sel[1], sel[0], wen, busy}. Bits 6..4 always read 0. Bit 0 always equals `timer_busy`.
- R2: After `por_n` is low, the status byte reads 0x00 (with `timer_busy` low) and all four grant/cancel outputs are low.
- R3: `wren_stb` sets the latch and `wrdi_stb` clears it. Either strobe is ignored while `timer_busy` is high.
- R4: An array write or status write raised while the latch is 0 is cancelled, and the latch stays 0.
- R5: A granted array write or status write clears the latch on the same edge as the grant.
- R6: For a 12-bit address, region select 00 protects nothing, 01 protects 0xC00..0xFFF, 10 protects 0x800..0xFFF, and 11 protects all addresses. An array write whose start address is protected is cancelled.
- R7: A status write is cancelled when the pin enable (bit 7) is 1 and `wp_pin_n` is low. `wp_pin_n` never affects an array write.
- R8: A granted status write loads only bits 7, 3 and 2 of `wrsr_data`. The other data bits have no effect.
- R9: While `timer_busy` is high, every write request is cancelled and status bits 7..1 hold their values, whatever `wp_pin_n` does.
- R10: `page_byte_ok` is 0 exactly when `page_addr` lies in the region that the current select bits protect.
- R11: `warm_rst` clears the latch and keeps the pin enable and the select bits.
- R12: Each request gives exactly one grant or one cancel pulse, one cycle after the strobe. A grant and a cancel are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| por_n | input | 1 | power-on reset, active low, asynchronous; clears all state |
| warm_rst | input | 1 | synchronous warm reset; clears only the latch |
| wren_stb | input | 1 | enable-latch command strobe |
| wrdi_stb | input | 1 | disable-latch command strobe |
| wr_req | input | 1 | array write request strobe |
| wr_addr | input | AW | start address of the array write |
| wrsr_req | input | 1 | status write request strobe |
| wrsr_data | input | 8 | data byte of the status write |
| wp_pin_n | input | 1 | write-protect pin, active low |
| timer_busy | input | 1 | high while the internal write timer runs |
| page_addr | input | AW | address of one byte within a page burst |
| status_byte | output | 8 | status byte for reads |
| wr_grant | output | 1 | array write may start |
| wr_cancel | output | 1 | array write discarded |
| sr_grant | output | 1 | status write may start |
| sr_cancel | output | 1 | status write discarded |
| page_byte_ok | output | 1 | the byte at `page_addr` may be written |

## Verification
The hardest case to reach is one where the protect pin is the only reason a write is refused. That needs three things at once: the pin enable has already been committed by an earlier status write, the latch has been set again afterwards, and the pin is low on the cycle of the request. A second hard case is a request or a pin change that lands inside a busy window. Directed sequences build each of these preconditions step by step. They also walk each select value across both edges of its protected region. A seeded random mix of strobes, pin levels and busy cycles then revisits the same states in orders the directed sequences do not cover.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_sel_e;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] sel;
    logic       wen;
  } sr_state_t;

  localparam int unsigned SR_LOCK_BIT = 7;
  localparam int unsigned SR_SEL_HI   = 3;
  localparam int unsigned SR_SEL_LO   = 2;

  function automatic logic [7:0] pack_status(sr_state_t s, logic busy);
    return {s.lock_en, 3'b000, s.sel, s.wen, busy};
  endfunction
endpackage

// File: rtl/eewp_region.sv
module eewp_region
  import eewp_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int unsigned TOP = AW - 1;

  always_comb begin
    case (prot_sel_e'(sel))
      PROT_NONE: hit = 1'b0;
      PROT_QTR:  hit = &addr[TOP -: 2];
      PROT_HALF: hit = addr[TOP];
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/eewp_regs.sv
module eewp_regs
  import eewp_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      set_wen,
  input  logic      clr_wen,
  input  logic      load_sr,
  input  logic [7:0] sr_data,
  output sr_state_t st
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= '0;
    end else begin
      if (clr_wen)      st.wen <= 1'b0;
      else if (set_wen) st.wen <= 1'b1;
      if (load_sr) begin
        st.lock_en <= sr_data[SR_LOCK_BIT];
        st.sel     <= sr_data[SR_SEL_HI:SR_SEL_LO];
      end
    end
  end
endmodule

// File: rtl/eewp_status_unit.sv
module eewp_status_unit
  import eewp_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst,
  input  logic          wren_stb,
  input  logic          wrdi_stb,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic          wrsr_req,
  input  logic [7:0]    wrsr_data,
  input  logic          wp_pin_n,
  input  logic          timer_busy,
  input  logic [AW-1:0] page_addr,
  output logic [7:0]    status_byte,
  output logic          wr_grant,
  output logic          wr_cancel,
  output logic          sr_grant,
  output logic          sr_cancel,
  output logic          page_byte_ok
);
  localparam int unsigned NPORT = 2;

  sr_state_t     st;
  logic [AW-1:0] q_addr [NPORT];
  logic          q_hit  [NPORT];

  assign q_addr[0] = wr_addr;
  assign q_addr[1] = page_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_region
    eewp_region #(.AW(AW)) u_region (
      .sel (st.sel),
      .addr(q_addr[g]),
      .hit (q_hit[g])
    );
  end

  logic open_gate, pin_block, wr_go, sr_go, set_wen, clr_wen;

  always_comb begin
    open_gate = st.wen & ~timer_busy & ~warm_rst;
    pin_block = st.lock_en & ~wp_pin_n;
    wr_go     = wr_req & open_gate & ~q_hit[0];
    sr_go     = wrsr_req & ~wr_req & open_gate & ~pin_block;
    set_wen   = wren_stb & ~timer_busy;
    clr_wen   = (wrdi_stb & ~timer_busy) | warm_rst | wr_go | sr_go;
  end

  eewp_regs u_regs (
    .clk    (clk),
    .por_n  (por_n),
    .set_wen(set_wen),
    .clr_wen(clr_wen),
    .load_sr(sr_go),
    .sr_data(wrsr_data),
    .st     (st)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wr_grant  <= 1'b0;
      wr_cancel <= 1'b0;
      sr_grant  <= 1'b0;
      sr_cancel <= 1'b0;
    end else begin
      wr_grant  <= wr_go;
      wr_cancel <= wr_req & ~wr_go;
      sr_grant  <= sr_go;
      sr_cancel <= wrsr_req & ~sr_go;
    end
  end

  assign status_byte  = pack_status(st, timer_busy);
  assign page_byte_ok = ~q_hit[1];
endmodule

// File: rtl/eewp_status_chk.sv
module eewp_status_chk #(
  parameter int unsigned AW = 12
) (
  input logic       clk,
  input logic       por_n,
  input logic       warm_rst,
  input logic       wp_pin_n,
  input logic       timer_busy,
  input logic [7:0] status_byte,
  input logic       wr_grant,
  input logic       wr_cancel,
  input logic       sr_grant,
  input logic       sr_cancel
);
  // R1
  zero_field_chk: assert property (@(posedge clk) disable iff (!por_n)
    status_byte[6:4] == 3'b000);
  // R1
  busy_mirror_chk: assert property (@(posedge clk) disable iff (!por_n)
    status_byte[0] == timer_busy);
  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_grant && wr_cancel) && !(sr_grant && sr_cancel));
  // R4
  grant_needs_wen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_grant || sr_grant) |-> $past(status_byte[1]));
  // R5
  wen_drops_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_grant || sr_grant) |-> !status_byte[1]);
  // R7
  pin_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    sr_grant |-> !($past(status_byte[7]) && !$past(wp_pin_n)));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(timer_busy) && !$past(warm_rst)) |-> $stable(status_byte[7:1]));
endmodule

bind eewp_status_unit eewp_status_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .warm_rst   (warm_rst),
  .wp_pin_n   (wp_pin_n),
  .timer_busy (timer_busy),
  .status_byte(status_byte),
  .wr_grant   (wr_grant),
  .wr_cancel  (wr_cancel),
  .sr_grant   (sr_grant),
  .sr_cancel  (sr_cancel)
);

// File: tb/eewp_status_unit_test.sv
module eewp_status_unit_test;
  localparam int unsigned AW = 12;

  logic clk = 1'b0;
  logic por_n, warm_rst, wren_stb, wrdi_stb, wr_req, wrsr_req, wp_pin_n, timer_busy;
  logic [AW-1:0] wr_addr, page_addr;
  logic [7:0] wrsr_data, status_byte;
  logic wr_grant, wr_cancel, sr_grant, sr_cancel, page_byte_ok;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic m_wen, m_lock;
  logic [1:0] m_sel;

  always #4 clk = ~clk;

  eewp_status_unit #(.AW(AW)) uut (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wren_stb(wren_stb),
    .wrdi_stb(wrdi_stb), .wr_req(wr_req), .wr_addr(wr_addr), .wrsr_req(wrsr_req),
    .wrsr_data(wrsr_data), .wp_pin_n(wp_pin_n), .timer_busy(timer_busy),
    .page_addr(page_addr), .status_byte(status_byte), .wr_grant(wr_grant),
    .wr_cancel(wr_cancel), .sr_grant(sr_grant), .sr_cancel(sr_cancel),
    .page_byte_ok(page_byte_ok)
  );

  function automatic logic prot(input logic [AW-1:0] a, input logic [1:0] s);
    case (s)
      2'b00:   return 1'b0;
      2'b01:   return a >= 12'hC00;
      2'b10:   return a >= 12'h800;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus at a falling edge, check after the next rising edge
  task automatic step(input logic wren, input logic wrdi, input logic wr,
                      input logic [AW-1:0] a, input logic sr, input logic [7:0] d,
                      input logic pin, input logic busy, input logic warm,
                      input logic [AW-1:0] pa);
    logic e_wr_ok, e_sr_ok;
    logic [7:0] e_st;
    wren_stb = wren; wrdi_stb = wrdi; wr_req = wr; wr_addr = a;
    wrsr_req = sr; wrsr_data = d; wp_pin_n = pin; timer_busy = busy;
    warm_rst = warm; page_addr = pa;
    e_wr_ok = m_wen && !busy && !warm && !prot(a, m_sel);
    e_sr_ok = m_wen && !busy && !warm && !wr && !(m_lock && !pin);
    @(posedge clk);
    @(negedge clk);
    if ((wr && e_wr_ok) || (sr && e_sr_ok) || warm || (wrdi && !busy)) m_wen = 1'b0;
    else if (wren && !busy) m_wen = 1'b1;
    if (sr && e_sr_ok) begin
      m_lock = d[7];
      m_sel  = d[3:2];
    end
    e_st = {m_lock, 3'b000, m_sel, m_wen, busy};
    #1;
    chk(status_byte == e_st, "R1/R3/R8/R11 status", status_byte, e_st);
    chk(wr_grant == (wr && e_wr_ok) && wr_cancel == (wr && !e_wr_ok),
        "R4/R6/R12 write outcome", {wr_grant, wr_cancel}, {wr && e_wr_ok, wr && !e_wr_ok});
    chk(sr_grant == (sr && e_sr_ok) && sr_cancel == (sr && !e_sr_ok),
        "R7/R9/R12 status-write outcome", {sr_grant, sr_cancel}, {sr && e_sr_ok, sr && !e_sr_ok});
    chk(page_byte_ok == !prot(pa, m_sel), "R10 page byte", page_byte_ok, !prot(pa, m_sel));
    wren_stb = 0; wrdi_stb = 0; wr_req = 0; wrsr_req = 0; warm_rst = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, 8'h00, 1, 0, 0, '0);
  endtask
  task automatic wren();
    step(1, 0, 0, '0, 0, 8'h00, 1, 0, 0, '0);
  endtask
  task automatic wrsr(input logic [7:0] d, input logic pin);
    wren();
    step(0, 0, 0, '0, 1, d, pin, 0, 0, '0);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic pin);
    wren();
    step(0, 0, 1, a, 0, 8'h00, pin, 0, 0, a);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7721));
    por_n = 0; warm_rst = 0; wren_stb = 0; wrdi_stb = 0; wr_req = 0; wrsr_req = 0;
    wr_addr = '0; wrsr_data = '0; wp_pin_n = 1; timer_busy = 0; page_addr = '0;
    m_wen = 0; m_lock = 0; m_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(status_byte == 8'h00, "R2 reset status", status_byte, 8'h00);
    chk({wr_grant, wr_cancel, sr_grant, sr_cancel} == 4'b0, "R2 reset outcomes",
        {wr_grant, wr_cancel, sr_grant, sr_cancel}, 0);
    por_n = 1;
    idle();
    // R4 write without latch
    step(0, 0, 1, 12'h010, 0, 8'h00, 1, 0, 0, 12'h010);
    // R3 enable then disable
    wren();
    step(0, 1, 0, '0, 0, 8'h00, 1, 0, 0, '0);
    // R5 granted write clears latch
    wr(12'h123, 1);
    // R8 all-ones data loads only bits 7,3,2 (status expect 0x8C)
    wrsr(8'hFF, 1);
    chk(status_byte == 8'h8C, "R8 masked load", status_byte, 8'h8C);
    // R7 pin low with lock enabled: status write refused, array write unaffected
    wrsr(8'h00, 0);
    step(0, 1, 0, '0, 0, 8'h00, 1, 0, 0, '0);
    wrsr(8'h80, 1);
    wr(12'h7FF, 0);
    // R6 each select value across region edges
    for (int s = 0; s < 4; s++) begin
      wrsr({6'b0, s[1:0]} << 2, 1);
      wr(12'h000, 1); wr(12'h7FF, 1); wr(12'h800, 1);
      wr(12'hBFF, 1); wr(12'hC00, 1); wr(12'hFFF, 1);
    end
    // R9 busy window: strobes ignored, pin toggles harmless
    wrsr(8'h84, 1);
    wren();
    step(0, 1, 0, '0, 0, 8'h00, 0, 1, 0, '0);
    step(0, 0, 1, 12'h001, 0, 8'h00, 0, 1, 0, '0);
    step(0, 0, 0, '0, 1, 8'h00, 1, 1, 0, '0);
    // R11 warm reset keeps nonvolatile bits
    wren();
    step(0, 0, 0, '0, 0, 8'h00, 1, 0, 1, '0);
    chk(status_byte == 8'h84, "R11 warm keep", status_byte, 8'h84);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [AW-1:0] ra, pa;
      logic [7:0] rd;
      logic pin, busy;
      op = $urandom % 7;
      ra = AW'($urandom); pa = AW'($urandom); rd = 8'($urandom);
      pin = 1'($urandom); busy = ($urandom % 8) == 0;
      case (op)
        0, 5: step(1, 0, 0, ra, 0, rd, pin, busy, 0, pa);
        1:    step(0, 1, 0, ra, 0, rd, pin, busy, 0, pa);
        2:    step(0, 0, 1, ra, 0, rd, pin, busy, 0, pa);
        3:    step(0, 0, 0, ra, 1, rd, pin, busy, 0, pa);
        4:    step(0, 0, 0, ra, 0, rd, pin, busy, ($urandom % 10) == 0, pa);
        default: step(0, 0, 0, ra, 0, rd, pin, busy, 0, pa);
      endcase
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule